// File: doc/BRIEF.md
# I2C Slave Address Matcher and Responder

This block is the slave side of an I2C controller. It samples the open-drain SCL and SDA lines and finds START and STOP conditions on them. After each START it shifts in the first byte and compares it with a programmable 7-bit own address. If general-call recognition is switched on, it also compares the byte with the all-zero general-call address. On a match it pulls SDA low in the ninth clock as an acknowledge. It then receives bytes into a data register, or sends bytes that software supplies.

Every bus event the slave takes part in raises an interrupt flag and posts an 8-bit status code. Events that end a ninth clock also hold SCL low until software clears the flag. This gives software time to read a received byte or to supply the next byte to send. The own-address input carries the 7-bit address in its upper seven bits and the general-call enable in bit 0. A separate acknowledge-enable input decides whether the slave answers at all and whether it acknowledges received data.

Top module: `i2c_slv_resp`

## Requirements
- R1: After reset the flag is clear, the status reads 0xF8 and neither SCL nor SDA is driven.
- R2: With ack_en high, an address byte whose upper seven bits equal own_cfg[7:1] is acknowledged (SDA low in the ninth clock). It posts 0x60 when bit 0 of the byte is 0 (write) and 0xA8 when it is 1 (read).
- R3: The byte 0x00 is a general call. It is acknowledged with status 0x70 only when own_cfg[0] is 1 and ack_en is high; otherwise it gets no acknowledge and raises no flag.
- R4: An address that does not match, or any address while ack_en is low, is not acknowledged and raises no flag. Later bytes are also ignored until the next START.
- R5: A data byte received after the own address is placed on rx_data. If ack_en is high at the end of its eighth bit it is acknowledged with status 0x80. Otherwise it is not acknowledged, reports 0x88, and the slave ignores the bus until the next START.
- R6: A data byte received after a general call reports 0x90 when acknowledged and 0x98 when not.
- R7: In transmit mode, clearing the flag loads tx_data and tx_last, and the byte goes out MSB first. A master acknowledge reports 0xB8, or 0xC8 if tx_last was set. A master NACK reports 0xC0. After 0xC0 or 0xC8 the slave releases SDA and ignores the bus until the next START.
- R8: A STOP or repeated START while the slave is addressed reports 0xA0 without holding SCL, and SDA is released.
- R9: Flag and status are set by the falling SCL edge that ends a ninth clock. From then on SCL is held low until flag_clr.
- R10: A flag_clr pulse clears the flag, releases SCL and returns the status to 0xF8. A new event in the same cycle takes priority over the clear.
- R11: The slave begins to pull SDA low only in a cycle that follows one in which SCL was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock hold) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_cfg | input | 8 | [7:1] own address, [0] general-call enable |
| ack_en | input | 1 | Respond to addresses and acknowledge data |
| tx_data | input | 8 | Next byte to send |
| tx_last | input | 1 | Marks tx_data as the final byte |
| flag_clr | input | 1 | One-cycle pulse that clears the flag |
| irq_flag | output | 1 | Event flag |
| status | output | 8 | Event status code |
| rx_data | output | 8 | Last byte received |

## Verification
Each SCL or SDA change takes two synchroniser cycles plus one register cycle to reach the outputs. The flag, status, rx_data and clock hold therefore appear three clocks after the SCL line falls at the end of a ninth bit. The acknowledge level on SDA appears three clocks after the eighth falling edge. The master model waits twelve clocks before each SCL edge and before each sample, so every level it reads has settled. The scoreboard monitor samples on the falling clock edge every cycle. It compares each queued expectation in the first cycle the flag shows, and checks the cleared state one cycle after its own flag_clr pulse.

// File: rtl/i2c_resp_pkg.sv
// Shared constants for the I2C slave responder: byte geometry, status
// codes posted with the event flag, and the responder state encoding.
package i2c_resp_pkg;
    localparam int BYTE_W = 8;
    localparam int ADR_W  = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [BYTE_W-1:0] ST_WR_ADR    = 8'h60;
    localparam logic [BYTE_W-1:0] ST_GC_ADR    = 8'h70;
    localparam logic [BYTE_W-1:0] ST_RX_ACK    = 8'h80;
    localparam logic [BYTE_W-1:0] ST_RX_NAK    = 8'h88;
    localparam logic [BYTE_W-1:0] ST_GC_RX_ACK = 8'h90;
    localparam logic [BYTE_W-1:0] ST_GC_RX_NAK = 8'h98;
    localparam logic [BYTE_W-1:0] ST_END       = 8'hA0;
    localparam logic [BYTE_W-1:0] ST_RD_ADR    = 8'hA8;
    localparam logic [BYTE_W-1:0] ST_TX_ACK    = 8'hB8;
    localparam logic [BYTE_W-1:0] ST_TX_NAK    = 8'hC0;
    localparam logic [BYTE_W-1:0] ST_TX_LAST   = 8'hC8;
    localparam logic [BYTE_W-1:0] ST_NONE      = 8'hF8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADR_ACK,
        S_RX,
        S_RX_ACK,
        S_TX_WAIT,
        S_TX,
        S_TX_ACK,
        S_IGNORE
    } rsp_state_t;
endpackage

// File: rtl/i2c_bus_sync.sv
// Bus line synchroniser and condition detector.
// Brings SCL and SDA into the clock domain through STAGES flops and keeps
// one more flop as the previous value. From those it flags SCL rising and
// falling edges and START/STOP conditions (SDA moving while SCL is high).
// Assumes the bus is much slower than clk, so one sample per level suffices.
module i2c_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES:0] scl_q;
    logic [STAGES:0] sda_q;
    logic            scl_p;
    logic            sda_p;

    // Shift both lines through the synchroniser chain; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-1:0], scl_i};
            sda_q <= {sda_q[STAGES-1:0], sda_i};
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];
    assign scl_p = scl_q[STAGES];
    assign sda_p = sda_q[STAGES];

    // Decode clock edges and bus conditions from current and previous samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        bus_start = scl_s & scl_p & sda_p & ~sda_s;
        bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2c_slv_core.sv
// Slave protocol engine.
// Shifts the address byte, decides on a match, drives the acknowledge, and
// runs the receive and transmit byte paths. It also owns the event flag,
// status code and clock hold. Assumes single-cycle event strobes from the
// synchroniser and that SDA is only changed by the slave while SCL is low.
module i2c_slv_core
    import i2c_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [ADR_W-1:0]  own_addr,
    input  logic              gc_en,
    input  logic              ack_en,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_last,
    input  logic              flag_clr,
    output logic              irq_flag,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] rx_data,
    output logic              scl_oe,
    output logic              sda_oe
);
    rsp_state_t        state;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              gc_sess;
    logic              rd_q;
    logic              ack_q;
    logic              mack;
    logic              last_q;
    logic              hold;
    logic              addressed;
    logic              hit_own;
    logic              hit_gc;
    logic              post;
    logic              post_hold;
    logic [BYTE_W-1:0] post_code;

    // Match the shifted address against own address and general call.
    always_comb begin
        hit_own = ack_en && (sh[BYTE_W-1:1] == own_addr);
        hit_gc  = ack_en && gc_en && (sh == '0);
    end

    // Flag whether the slave currently takes part in a transfer.
    always_comb begin
        addressed = (state == S_ADR_ACK) || (state == S_RX) ||
                    (state == S_RX_ACK)  || (state == S_TX_WAIT) ||
                    (state == S_TX)      || (state == S_TX_ACK);
    end

    // Decide which event, if any, is reported this cycle.
    always_comb begin
        post      = 1'b0;
        post_hold = 1'b0;
        post_code = ST_NONE;
        if (bus_start || bus_stop) begin
            if (addressed) begin
                post      = 1'b1;
                post_code = ST_END;
            end
        end else if (scl_fall) begin
            case (state)
                S_ADR_ACK: begin
                    post      = 1'b1;
                    post_hold = 1'b1;
                    if (rd_q)
                        post_code = ST_RD_ADR;
                    else if (gc_sess)
                        post_code = ST_GC_ADR;
                    else
                        post_code = ST_WR_ADR;
                end
                S_RX_ACK: begin
                    post      = 1'b1;
                    post_hold = 1'b1;
                    if (gc_sess)
                        post_code = ack_q ? ST_GC_RX_ACK : ST_GC_RX_NAK;
                    else
                        post_code = ack_q ? ST_RX_ACK : ST_RX_NAK;
                end
                S_TX_ACK: begin
                    post      = 1'b1;
                    post_hold = 1'b1;
                    if (!mack)
                        post_code = ST_TX_NAK;
                    else if (last_q)
                        post_code = ST_TX_LAST;
                    else
                        post_code = ST_TX_ACK;
                end
                default: post = 1'b0;
            endcase
        end
    end

    // Event flag, status and clock hold; a new event beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
            status   <= ST_NONE;
            hold     <= 1'b0;
        end else if (post) begin
            irq_flag <= 1'b1;
            status   <= post_code;
            hold     <= post_hold;
        end else if (flag_clr) begin
            irq_flag <= 1'b0;
            status   <= ST_NONE;
            hold     <= 1'b0;
        end
    end

    assign scl_oe = hold;

    // Capture the received byte when its ninth clock ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_data <= '0;
        else if (state == S_RX_ACK && scl_fall && !bus_start && !bus_stop)
            rx_data <= sh;
    end

    // Main bit-level sequencer for address, receive and transmit phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            sh      <= '0;
            cnt     <= '0;
            gc_sess <= 1'b0;
            rd_q    <= 1'b0;
            ack_q   <= 1'b0;
            mack    <= 1'b0;
            last_q  <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (bus_start) begin
            state  <= S_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (bus_stop) begin
            state  <= S_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                S_ADDR: begin
                    if (scl_rise && cnt != CNT_W'(BYTE_W)) begin
                        sh  <= {sh[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                        if (hit_own || hit_gc) begin
                            sda_oe  <= 1'b1;
                            gc_sess <= hit_gc;
                            rd_q    <= sh[0];
                            state   <= S_ADR_ACK;
                        end else begin
                            state <= S_IGNORE;
                        end
                    end
                end
                S_ADR_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= rd_q ? S_TX_WAIT : S_RX;
                    end
                end
                S_RX: begin
                    if (scl_rise && cnt != CNT_W'(BYTE_W)) begin
                        sh  <= {sh[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                        ack_q  <= ack_en;
                        sda_oe <= ack_en;
                        state  <= S_RX_ACK;
                    end
                end
                S_RX_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ack_q ? S_RX : S_IGNORE;
                    end
                end
                S_TX_WAIT: begin
                    if (flag_clr && irq_flag) begin
                        sh     <= tx_data;
                        last_q <= tx_last;
                        sda_oe <= ~tx_data[BYTE_W-1];
                        cnt    <= '0;
                        state  <= S_TX;
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            sda_oe <= 1'b0;
                            state  <= S_TX_ACK;
                        end else begin
                            sh     <= {sh[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~sh[BYTE_W-2];
                            cnt    <= cnt + 1'b1;
                        end
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise)
                        mack <= ~sda_s;
                    else if (scl_fall)
                        state <= (mack && !last_q) ? S_TX_WAIT : S_IGNORE;
                end
                default: state <= state;
            endcase
        end
    end

    // R9: the clock is only held while an event is pending.
    p_hold_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> irq_flag);

    // R9: a posted event shows on the flag in the next cycle.
    p_post_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> irq_flag);

    // R10: a clear without a competing event restores the idle status.
    p_clear_idles_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !post) |=> (status == ST_NONE && !scl_oe));

    // R8: SDA is let go once a STOP is seen.
    p_stop_releases_sda_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_oe);

    // R11: the slave starts pulling SDA only after SCL was low.
    p_drive_on_low_scl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s));

    // R4: a skipped transfer never drives SDA.
    p_ignore_is_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE || state == S_IDLE) |-> !sda_oe);
endmodule

// File: rtl/i2c_slv_resp.sv
// Top level of the I2C slave responder.
// Splits the own-address configuration and connects the line synchroniser
// to the protocol engine. Assumes external open-drain pads: an *_oe output
// high means the pad pulls the line low.
module i2c_slv_resp
    import i2c_resp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [BYTE_W-1:0] own_cfg,
    input  logic              ack_en,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_last,
    input  logic              flag_clr,
    output logic              irq_flag,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] rx_data
);
    logic scl_s;
    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic bus_start;
    logic bus_stop;

    i2c_bus_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_slv_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .own_addr  (own_cfg[BYTE_W-1:1]),
        .gc_en     (own_cfg[0]),
        .ack_en    (ack_en),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .flag_clr  (flag_clr),
        .irq_flag  (irq_flag),
        .status    (status),
        .rx_data   (rx_data),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );
endmodule

// File: tb/i2c_slv_resp_tb_top.sv
// Scoreboard bench: a bit-banged master drives the bus, and each expected
// event is queued before the stimulus that causes it. A monitor pops and
// compares entries as the flag appears, then services the flag.
module i2c_slv_resp_tb_top;
    localparam int Q = 12;

    typedef struct {
        logic [7:0] code;
        logic       chk_rx;
        logic [7:0] rx;
        logic       hold;
        logic [7:0] tx;
        logic       last;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [7:0] own_cfg = {7'h42, 1'b0};
    logic       ack_en = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       tx_last = 1'b0;
    logic       flag_clr = 1'b0;
    logic       scl_oe, sda_oe, irq_flag;
    logic [7:0] status, rx_data;
    logic       scl_line, sda_line;
    int         n_chk = 0;
    int         n_fail = 0;
    int         r11_bad = 0;
    logic       done = 1'b0;
    exp_t       expq[$];

    always #2 clk = ~clk;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    i2c_slv_resp dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_line),
        .sda_i    (sda_line),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .own_cfg  (own_cfg),
        .ack_en   (ack_en),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .flag_clr (flag_clr),
        .irq_flag (irq_flag),
        .status   (status),
        .rx_data  (rx_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] code, input logic chk_rx, input logic [7:0] rx,
                        input logic hold, input logic [7:0] tx, input logic last,
                        input string req);
        exp_t e;
        e.code = code; e.chk_rx = chk_rx; e.rx = rx; e.hold = hold;
        e.tx = tx; e.last = last; e.req = req;
        expq.push_back(e);
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic scl_up();
        scl_m = 1'b1;
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; qwait();
        scl_up(); qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; qwait();
        scl_up(); qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic m_bit(input logic b, output logic s);
        sda_m = b; qwait();
        scl_up(); qwait();
        s = sda_line; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic m_wr(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) m_bit(b[i], s);
        m_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic m_rd(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, s);
            b[i] = s;
        end
        m_bit(~give_ack, s);
    endtask

    // Scoreboard monitor: compare each flagged event, then service it.
    initial begin
        exp_t e;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (irq_flag) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R4", "unexpected flag status", status, 8'hF8);
                end else begin
                    e = expq.pop_front();
                    check(status == e.code, e.req, "status", status, e.code);
                    if (e.chk_rx)
                        check(rx_data == e.rx, e.req, "rx_data", rx_data, e.rx);
                    check(scl_oe == e.hold, "R9", "SCL hold", scl_oe, e.hold);
                    tx_data = e.tx;
                    tx_last = e.last;
                end
                repeat (3) @(negedge clk);
                flag_clr = 1'b1;
                @(negedge clk);
                flag_clr = 1'b0;
                check(!irq_flag && status == 8'hF8 && !scl_oe, "R10", "cleared status",
                      status, 8'hF8);
            end
        end
    end

    // R11 watcher: SDA drive may only start after a low SCL sample.
    initial begin
        logic prev_oe;
        logic prev_scl;
        prev_oe = 1'b0;
        prev_scl = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && sda_oe && !prev_oe && prev_scl) r11_bad++;
            prev_oe = sda_oe;
            prev_scl = scl_line;
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        logic       ak;
        logic [7:0] rb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq_flag == 1'b0, "R1", "flag after reset", irq_flag, 0);
        check(status == 8'hF8, "R1", "status after reset", status, 8'hF8);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "lines released", {scl_oe, sda_oe}, 0);

        // R2/R5: write to own address, one acked byte, one refused byte.
        m_start();
        push(8'h60, 0, 0, 1, 0, 0, "R2");
        m_wr(8'h84, ak);
        check(ak, "R2", "own write address ack", ak, 1);
        push(8'h80, 1, 8'hA5, 1, 0, 0, "R5");
        m_wr(8'hA5, ak);
        check(ak, "R5", "data ack", ak, 1);
        ack_en = 1'b0;
        push(8'h88, 1, 8'h3C, 1, 0, 0, "R5");
        m_wr(8'h3C, ak);
        check(!ak, "R5", "data nack", ak, 0);
        ack_en = 1'b1;
        m_wr(8'h55, ak);
        check(!ak, "R5", "ignored after nack", ak, 0);
        m_stop();

        // R4: foreign address.
        m_start();
        m_wr(8'h26, ak);
        check(!ak, "R4", "foreign address nack", ak, 0);
        m_wr(8'h00, ak);
        check(!ak, "R4", "byte after foreign address ignored", ak, 0);
        m_stop();

        // R4: own address while ack_en low.
        ack_en = 1'b0;
        m_start();
        m_wr(8'h84, ak);
        check(!ak, "R4", "own address with ack_en low", ak, 0);
        m_stop();
        ack_en = 1'b1;

        // R3: general call disabled then enabled; R6 data after it.
        m_start();
        m_wr(8'h00, ak);
        check(!ak, "R3", "general call disabled nack", ak, 0);
        m_stop();
        own_cfg[0] = 1'b1;
        m_start();
        push(8'h70, 0, 0, 1, 0, 0, "R3");
        m_wr(8'h00, ak);
        check(ak, "R3", "general call ack", ak, 1);
        push(8'h90, 1, 8'h77, 1, 0, 0, "R6");
        m_wr(8'h77, ak);
        check(ak, "R6", "general call data ack", ak, 1);
        ack_en = 1'b0;
        push(8'h98, 1, 8'hE1, 1, 0, 0, "R6");
        m_wr(8'hE1, ak);
        check(!ak, "R6", "general call data nack", ak, 0);
        ack_en = 1'b1;
        m_stop();
        own_cfg[0] = 1'b0;

        // R7: read two bytes, second marked last.
        m_start();
        push(8'hA8, 0, 0, 1, 8'hC3, 0, "R2");
        m_wr(8'h85, ak);
        check(ak, "R2", "own read address ack", ak, 1);
        push(8'hB8, 0, 0, 1, 8'h5A, 1, "R7");
        m_rd(1'b1, rb);
        check(rb == 8'hC3, "R7", "first read byte", rb, 8'hC3);
        push(8'hC8, 0, 0, 1, 0, 0, "R7");
        m_rd(1'b1, rb);
        check(rb == 8'h5A, "R7", "last read byte", rb, 8'h5A);
        m_rd(1'b1, rb);
        check(rb == 8'hFF, "R7", "bus released after last byte", rb, 8'hFF);
        m_stop();

        // R7: master NACK ends the read.
        m_start();
        push(8'hA8, 0, 0, 1, 8'h81, 0, "R2");
        m_wr(8'h85, ak);
        push(8'hC0, 0, 0, 1, 0, 0, "R7");
        m_rd(1'b0, rb);
        check(rb == 8'h81, "R7", "nacked read byte", rb, 8'h81);
        m_stop();

        // R8: STOP while addressed.
        m_start();
        push(8'h60, 0, 0, 1, 0, 0, "R2");
        m_wr(8'h84, ak);
        push(8'h80, 1, 8'h11, 1, 0, 0, "R5");
        m_wr(8'h11, ak);
        push(8'hA0, 0, 0, 0, 0, 0, "R8");
        m_stop();
        qwait();

        // R8: repeated START while addressed, then a read.
        m_start();
        push(8'h60, 0, 0, 1, 0, 0, "R2");
        m_wr(8'h84, ak);
        push(8'hA0, 0, 0, 0, 0, 0, "R8");
        m_start();
        push(8'hA8, 0, 0, 1, 8'h96, 0, "R2");
        m_wr(8'h85, ak);
        check(ak, "R8", "address after repeated start", ak, 1);
        push(8'hC0, 0, 0, 1, 0, 0, "R7");
        m_rd(1'b0, rb);
        check(rb == 8'h96, "R7", "byte after repeated start", rb, 8'h96);
        m_stop();
        repeat (4 * Q) @(negedge clk);

        check(expq.size() == 0, "R9", "expected events left", expq.size(), 0);
        check(r11_bad == 0, "R11", "SDA drive starts with SCL high", r11_bad, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule